// File: doc/BRIEF.md
# I2S Transmit Nibble-Stream Packer

This block produces a master-mode I2S transmit stream for a 4-bit parallel output port. The bit clock, the word select and the serial data are not driven on pins of their own: each is one bit of a 4-bit nibble, and eight nibbles make up one 32-bit output word. A consumer running from the master clock drains those words through a valid/ready handshake. The bit clock is synthesised inside the nibble stream, where it toggles on every nibble. Each data bit is held across two nibbles, so one output word covers four bit-clock periods.

Stereo PCM pairs enter through a second valid/ready handshake. A pair is taken only at a frame boundary. A frame holds two 32-bit channel slots, which is 64 bit periods or 16 output words. The sequencer has two named states:

- `ST_FETCH` is the frame-boundary cycle. `in_ready` is high and `out_valid` is low. If a pair is offered it is latched; if not, zeros are latched. Transition `FETCH->STREAM` always happens after one cycle.
- `ST_STREAM` presents words with `out_valid` high. Transition `STREAM->STREAM` happens on every accepted word except the last. Transition `STREAM->FETCH` happens on acceptance of the last word of the frame.

Top module: `i2s_nibble_packer`

## Requirements
- R1: Each nibble is laid out as bit0 = bit clock, bit1 = serial data, bit2 = word select, bit3 = constant 0. Nibble k of a word sits at bits 4k+3..4k, and the earliest nibble is at k = 0.
- R2: The bit clock is 0 in the first nibble of every bit period and 1 in the second, so it toggles on every nibble. In an output word the bit-clock bits read 0x10101010 under mask 0x11111111.
- R3: Within one bit period, the data bit and the word-select bit have the same value in both nibbles.
- R4: A frame is 16 words, which is 64 bit periods. The left channel is sent MSB first while word select is 0, then the right channel MSB first while word select is 1.
- R5: Word select changes one bit period before each channel's MSB. Bit period 0 of a frame carries the previous frame's right LSB with word select 0. Bit period 32 carries the left LSB with word select 1.
- R6: A sample pair is accepted only in the frame-boundary cycle. Only there is `in_ready` high, and `out_valid` is low in that cycle. `in_valid` at any other time has no effect on the stream.
- R7: If no pair is offered at a frame boundary, the frame carries zero data. The bit clock and word select keep their normal pattern.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. The stream position advances only on an accepted word.
- R9: After reset the block is in the frame-boundary cycle. The first frame's first nibble has word select 0, bit clock 0, and previous-LSB data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master-clock domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair taken this cycle (frame boundary) |
| in_left | input | SLOT_BITS | Left-channel sample |
| in_right | input | SLOT_BITS | Right-channel sample |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Eight packed nibbles, earliest in bits 3..0 |

## Verification
The assertions check the per-word format on every cycle:
- the zero bit and the bit-clock pattern,
- the pairing of data and word-select bits across the two nibbles of a bit period,
- that `in_ready` and `out_valid` are never high together,
- that the word holds during a stall.

Only the bench scenarios can show the serial content, because that depends on whole frames of history. These are the MSB-first order, the word-select lead of one bit period, the carry of the right LSB into the next frame, zero-fill when no pair is offered, and that `in_valid` mid-frame is ignored.

// File: rtl/i2s_pk_pkg.sv
package i2s_pk_pkg;
    localparam int WORD_W        = 32;
    localparam int NIBBLES       = WORD_W / 4;
    localparam int BITS_PER_WORD = NIBBLES / 2;

    typedef enum logic [0:0] {
        ST_FETCH  = 1'b0,
        ST_STREAM = 1'b1
    } pk_state_e;

    typedef struct packed {
        logic zero;
        logic lrck;
        logic sdat;
        logic bclk;
    } nibble_t;
endpackage

// File: rtl/i2s_pk_seq.sv
module i2s_pk_seq
    import i2s_pk_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    localparam int WORDS    = (2 * SLOT_BITS) / BITS_PER_WORD,
    localparam int WIDX_W   = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SLOT_BITS-1:0] in_left,
    input  logic [SLOT_BITS-1:0] in_right,
    input  logic                 out_ready,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [WIDX_W-1:0]    widx,
    output logic [SLOT_BITS-1:0] left_q,
    output logic [SLOT_BITS-1:0] right_q,
    output logic                 prev_lsb
);
    pk_state_e state_q, state_d;
    logic      accept;
    logic      last_word;

    assign accept    = (state_q == ST_STREAM) && out_ready;
    assign last_word = (widx == WIDX_W'(WORDS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_STREAM;
            ST_STREAM: if (accept && last_word) state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_FETCH:  in_ready  = 1'b1;
            ST_STREAM: out_valid = 1'b1;
            default:   ;
        endcase
    end

    // frame position and sample latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx     <= '0;
            left_q   <= '0;
            right_q  <= '0;
            prev_lsb <= 1'b0;
        end else if (state_q == ST_FETCH) begin
            widx     <= '0;
            prev_lsb <= right_q[0];
            left_q   <= in_valid ? in_left  : '0;
            right_q  <= in_valid ? in_right : '0;
        end else if (accept) begin
            widx <= last_word ? '0 : widx + WIDX_W'(1);
        end
    end
endmodule

// File: rtl/i2s_pk_word.sv
module i2s_pk_word
    import i2s_pk_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    localparam int WORDS    = (2 * SLOT_BITS) / BITS_PER_WORD,
    localparam int WIDX_W   = $clog2(WORDS)
) (
    input  logic [WIDX_W-1:0]    widx,
    input  logic [SLOT_BITS-1:0] left_q,
    input  logic [SLOT_BITS-1:0] right_q,
    input  logic                 prev_lsb,
    output logic [WORD_W-1:0]    word
);
    logic [BITS_PER_WORD-1:0] dbit;
    logic [BITS_PER_WORD-1:0] lbit;

    // serial data and word select for each bit period in this word
    always_comb begin
        for (int p = 0; p < BITS_PER_WORD; p++) begin
            int b;
            b = int'(widx) * BITS_PER_WORD + p;
            lbit[p] = (b >= SLOT_BITS);
            if (b == 0)
                dbit[p] = prev_lsb;
            else if (b <= SLOT_BITS)
                dbit[p] = left_q[SLOT_BITS - b];
            else
                dbit[p] = right_q[2 * SLOT_BITS - b];
        end
    end

    generate
        for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
            nibble_t nib;
            assign nib.zero = 1'b0;
            assign nib.lrck = lbit[k / 2];
            assign nib.sdat = dbit[k / 2];
            assign nib.bclk = 1'(k % 2);
            assign word[4*k +: 4] = nib;
        end
    endgenerate
endmodule

// File: rtl/i2s_nibble_packer.sv
module i2s_nibble_packer
    import i2s_pk_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    localparam int WORDS    = (2 * SLOT_BITS) / BITS_PER_WORD,
    localparam int WIDX_W   = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [SLOT_BITS-1:0] in_left,
    input  logic [SLOT_BITS-1:0] in_right,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data
);
    logic [WIDX_W-1:0]    widx;
    logic [SLOT_BITS-1:0] left_q, right_q;
    logic                 prev_lsb;

    i2s_pk_seq #(.SLOT_BITS(SLOT_BITS)) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid), .widx(widx),
        .left_q(left_q), .right_q(right_q), .prev_lsb(prev_lsb)
    );

    i2s_pk_word #(.SLOT_BITS(SLOT_BITS)) word_i (
        .widx(widx), .left_q(left_q), .right_q(right_q),
        .prev_lsb(prev_lsb), .word(out_data)
    );
endmodule

// File: rtl/i2s_nibble_packer_chk.sv
module i2s_nibble_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data
);
    function automatic logic pairs_ok(input logic [31:0] w);
        logic ok;
        ok = 1'b1;
        for (int p = 0; p < 4; p++) begin
            if (w[8*p+1] != w[8*p+5]) ok = 1'b0;
            if (w[8*p+2] != w[8*p+6]) ok = 1'b0;
        end
        return ok;
    endfunction

    p_zero_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & 32'h8888_8888) == 32'h0));

    p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & 32'h1111_1111) == 32'h1010_1010));

    p_bit_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pairs_ok(out_data));

    p_boundary_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind i2s_nibble_packer i2s_nibble_packer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
);

// File: tb/i2s_nibble_packer_tb_top.sv
module i2s_nibble_packer_tb_top;
    localparam int SLOT = 32;
    localparam logic [63:0] VEC [4] = '{
        64'h8000_0001_7FFF_FFFF,
        64'hA5A5_5A5A_0F0F_F0F1,
        64'h1234_5678_9ABC_DEF0,
        64'hFFFF_FFFF_0000_0001
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [SLOT-1:0] in_left = '0, in_right = '0;
    logic [31:0] out_data;
    int checks = 0, errors = 0;
    logic plsb = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2s_nibble_packer #(.SLOT_BITS(SLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] exp_word(int w, logic [31:0] l, logic [31:0] r, logic pl);
        logic [31:0] x;
        x = '0;
        for (int k = 0; k < 8; k++) begin
            int b;
            logic d;
            b = 4 * w + k / 2;
            if (b == 0)        d = pl;
            else if (b <= 32)  d = l[32 - b];
            else               d = r[64 - b];
            x[4*k]   = 1'(k % 2);
            x[4*k+1] = d;
            x[4*k+2] = (b >= 32);
        end
        return x;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one frame: offer (or not) a pair, then drain 16 words
    task automatic run_frame(logic [31:0] l, logic [31:0] r, bit give, int stall_at, bit junk);
        logic [31:0] el, er;
        check("R6 in_ready at boundary", {30'b0, in_ready, out_valid}, 32'h2);
        in_valid = give; in_left = l; in_right = r;
        @(posedge clk); #1;
        in_valid = 1'b0;
        el = give ? l : '0;
        er = give ? r : '0;
        if (junk) begin in_valid = 1'b1; in_left = ~l; in_right = ~r; end
        out_ready = 1'b1;
        for (int w = 0; w < 16; w++) begin
            @(negedge clk);
            check(give ? "R4 R5 word content" : "R7 zero frame",
                  out_data, exp_word(w, el, er, plsb));
            check("R6 out_valid in stream", {31'b0, out_valid}, 32'h1);
            if (w == stall_at) begin
                out_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check("R8 stalled word held", out_data, exp_word(w, el, er, plsb));
                end
                out_ready = 1'b1;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        plsb = er[0];
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 reset handshake", {30'b0, in_ready, out_valid}, 32'h2);
        // table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < 4; i++)
            run_frame(VEC[i][63:32], VEC[i][31:0], 1'b1, -1, 1'b0);
        // R7: no pair offered, previous right LSB still leads the frame
        run_frame('0, '0, 1'b0, -1, 1'b0);
        // R8: stalls at the first and last word
        run_frame(32'hC3C3_3C3C, 32'h0000_0003, 1'b1, 0, 1'b0);
        run_frame(32'h0F00_00F0, 32'h8000_0000, 1'b1, 15, 1'b0);
        // R6: in_valid during streaming is ignored
        run_frame(32'h5555_AAAA, 32'h3333_CCCC, 1'b1, 7, 1'b1);
        // R9: reset mid-frame returns to boundary with zero history
        run_frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, -1, 1'b0);
        in_valid = 1'b1; in_left = 32'h8000_0000; in_right = '1;
        @(posedge clk); #1; in_valid = 1'b0; out_ready = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        plsb = 1'b0;
        run_frame(32'h8000_0000, 32'h0000_0000, 1'b1, -1, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule